// File: doc/BRIEF.md
# Programmable Colour Subcarrier Generator

This block synthesises the colour subcarrier for a composite video encoder. A 24-bit phase accumulator runs on every cycle of the pixel clock. On each cycle it adds a frequency word, and the upper phase bits drive a quarter-wave sine generator. That generator supplies signed sine and cosine values for chroma modulation and colour burst. Software writes the frequency word one byte at a time into a shadow copy. The word moves into the accumulator path as a whole at the next line start, so a partly written word never reaches the output.

The phase can be re-aligned to the horizontal sync reference point, which is the 50% point of the sync leading edge. On lines where phase reset is enabled, the accumulator is loaded with a value built from an 8-bit seed and a 9-bit phase offset. The offset trims out delays outside the block, and its nominal value is zero. A 2-bit format field selects NTSC or PAL. In PAL the cosine (V) output changes sign on alternate lines.

Top module: `subcarrier_dds`

## Requirements
- R1: After synchronous reset, the accumulator, the active frequency word and the line-alternation flag are all zero, so phase_out = 0, sin_out = 0 and cos_out = +511.
- R2: On every clock with no phase load, the 24-bit accumulator adds the active frequency word modulo 2^24. phase_out is accumulator bits [23:14].
- R3: A write with cfg_wr = 1 stores cfg_byte into the shadow byte chosen by cfg_sel: 0 selects bits [7:0], 1 selects [15:8] and 2 selects [23:16]. cfg_sel = 3 is ignored. Shadow writes do not change the phase step until the next line start.
- R4: A line_start pulse copies the whole shadow word into the active word, and the new step applies from the following clock.
- R5: When sync_ref and reset_en are both 1, the accumulator loads {seed, ofs_msb, ofs_lo, 7'b0} instead of adding. A sync_ref pulse with reset_en = 0 has no effect.
- R6: Let q = phase_out[9:8] and i = phase_out[7:0]. Let k = i when q[0] = 0 and k = 256 - i when q[0] = 1. Let m = floor(511*k*(512-k)/65536). Then sin_out = m when q[1] = 0 and -m when q[1] = 1.
- R7: cos_out is the R6 value taken at phase_out + 256 (mod 1024). It is negated when the line-alternation flag is set.
- R8: When fmt_sel = 01 (PAL), the flag toggles on every line_start. For any other value (00 NTSC, 10 and 11 reserved), the flag is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Frequency byte write strobe |
| cfg_sel | input | 2 | Frequency byte select |
| cfg_byte | input | 8 | Frequency byte data |
| ofs_msb | input | 1 | Phase offset bit 8 |
| ofs_lo | input | 8 | Phase offset bits 7..0 |
| seed | input | 8 | Phase seed byte |
| fmt_sel | input | 2 | Video format select |
| line_start | input | 1 | Line start pulse |
| sync_ref | input | 1 | Sync 50% reference pulse |
| reset_en | input | 1 | Allow phase load on this line |
| phase_out | output | 10 | Subcarrier phase |
| sin_out | output | 10 | Signed sine (U carrier) |
| cos_out | output | 10 | Signed cosine (V carrier) |

## Verification
The hardest state to reach is every one of the 1024 phase points. A free-running accumulator with a realistic frequency word skips almost all of them. The bench therefore programs a step of exactly one phase unit per clock, then sweeps the full circle and compares both waveform outputs at every point. The PAL sign alternation is reached by switching the format and pulsing line starts while the phase is frozen with a zero step.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int ACC_W  = 24;
    localparam int PH_W   = 10;
    localparam int AMP_W  = 10;
    localparam int SEED_W = 8;
    localparam int OFS_W  = 9;

    typedef enum logic [1:0] {
        FMT_NTSC = 2'b00,
        FMT_PAL  = 2'b01,
        FMT_RSV2 = 2'b10,
        FMT_RSV3 = 2'b11
    } fmt_e;

    typedef struct packed {
        logic [PH_W-1:0]         phase;
        logic signed [AMP_W-1:0] sin_v;
        logic signed [AMP_W-1:0] cos_v;
    } carrier_t;

    // parabolic quarter-wave magnitude, k in 0..full
    function automatic int quarter_mag(int k, int full, int amp);
        return (amp * k * (2 * full - k)) / (full * full);
    endfunction
endpackage

// File: rtl/sc_freq_buf.sv
module sc_freq_buf #(
    parameter int ACC_W = sc_pkg::ACC_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr,
    input  logic [$clog2(ACC_W/8)-1:0]    sel,
    input  logic [7:0]                    wdata,
    input  logic                          take,
    output logic [ACC_W-1:0]              active
);
    localparam int NB    = ACC_W / 8;
    localparam int SEL_W = $clog2(NB);

    logic [NB-1:0][7:0] shadow;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                shadow[b] <= '0;
            else if (wr && sel == SEL_W'(b))
                shadow[b] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            active <= '0;
        else if (take)
            active <= shadow;
    end

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(active)); // R3
    AST_ACTIVE_TAKE: assert property (@(posedge clk) disable iff (rst)
        take |=> active == $past(shadow)); // R4
endmodule

// File: rtl/sc_phase_acc.sv
module sc_phase_acc #(
    parameter int ACC_W = sc_pkg::ACC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ACC_W-1:0] step,
    input  logic             load_en,
    input  logic [ACC_W-1:0] load_val,
    output logic [ACC_W-1:0] acc
);
    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (load_en)
            acc <= load_val;
        else
            acc <= acc + step;
    end

    AST_LOAD_PHASE: assert property (@(posedge clk) disable iff (rst)
        load_en |=> acc == $past(load_val)); // R5
    AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> acc - $past(acc) == $past(step)); // R2
endmodule

// File: rtl/sc_wave_lut.sv
module sc_wave_lut #(
    parameter int PH_W  = sc_pkg::PH_W,
    parameter int AMP_W = sc_pkg::AMP_W
) (
    input  logic [PH_W-1:0]         phase,
    input  logic                    negate,
    output logic signed [AMP_W-1:0] value
);
    localparam int QW   = PH_W - 2;
    localparam int FULL = 1 << QW;
    localparam int AMP  = (1 << (AMP_W - 1)) - 1;

    logic [QW:0]             k;
    logic signed [AMP_W-1:0] mag;
    logic signed [AMP_W-1:0] signed_v;

    always_comb begin
        if (phase[PH_W-2])
            k = (QW+1)'(FULL) - {1'b0, phase[QW-1:0]};
        else
            k = {1'b0, phase[QW-1:0]};
        mag      = AMP_W'(sc_pkg::quarter_mag(int'(k), FULL, AMP));
        signed_v = phase[PH_W-1] ? -mag : mag;
        value    = negate ? -signed_v : signed_v;
    end
endmodule

// File: rtl/subcarrier_dds.sv
module subcarrier_dds
    import sc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [1:0]       cfg_sel,
    input  logic [7:0]       cfg_byte,
    input  logic             ofs_msb,
    input  logic [7:0]       ofs_lo,
    input  logic [7:0]       seed,
    input  logic [1:0]       fmt_sel,
    input  logic             line_start,
    input  logic             sync_ref,
    input  logic             reset_en,
    output logic [9:0]       phase_out,
    output logic [9:0]       sin_out,
    output logic [9:0]       cos_out
);
    localparam int PAD     = ACC_W - SEED_W - OFS_W;
    localparam int QUARTER = 1 << (PH_W - 2);

    logic [ACC_W-1:0] active_step;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] load_val;
    logic             v_flip;
    carrier_t         car;

    assign load_val = {seed, ofs_msb, ofs_lo, {PAD{1'b0}}};

    sc_freq_buf #(.ACC_W(ACC_W)) u_freq (
        .clk(clk), .rst(rst), .wr(cfg_wr), .sel(cfg_sel),
        .wdata(cfg_byte), .take(line_start), .active(active_step)
    );

    sc_phase_acc #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst(rst), .step(active_step),
        .load_en(sync_ref && reset_en), .load_val(load_val), .acc(acc)
    );

    always_ff @(posedge clk) begin
        if (rst)
            v_flip <= 1'b0;
        else if (fmt_e'(fmt_sel) != FMT_PAL)
            v_flip <= 1'b0;
        else if (line_start)
            v_flip <= ~v_flip;
    end

    assign car.phase = acc[ACC_W-1 -: PH_W];

    sc_wave_lut #(.PH_W(PH_W), .AMP_W(AMP_W)) u_sin (
        .phase(car.phase), .negate(1'b0), .value(car.sin_v)
    );
    sc_wave_lut #(.PH_W(PH_W), .AMP_W(AMP_W)) u_cos (
        .phase(car.phase + PH_W'(QUARTER)), .negate(v_flip), .value(car.cos_v)
    );

    assign phase_out = car.phase;
    assign sin_out   = car.sin_v;
    assign cos_out   = car.cos_v;

    AST_FLIP_NONPAL: assert property (@(posedge clk) disable iff (rst)
        (fmt_sel != FMT_PAL) |=> !v_flip); // R8
    AST_FLIP_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (fmt_sel == FMT_PAL && line_start) |=> v_flip != $past(v_flip)); // R8
    AST_SIN_RANGE: assert property (@(posedge clk) disable iff (rst)
        sin_out != 10'h200); // R6
    AST_COS_RANGE: assert property (@(posedge clk) disable iff (rst)
        cos_out != 10'h200); // R7
endmodule

// File: tb/sim_subcarrier_dds.sv
module sim_subcarrier_dds;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [7:0] cfg_byte = '0;
    logic       ofs_msb = 1'b0;
    logic [7:0] ofs_lo = '0;
    logic [7:0] seed = '0;
    logic [1:0] fmt_sel = 2'b00;
    logic       line_start = 1'b0;
    logic       sync_ref = 1'b0;
    logic       reset_en = 1'b0;
    logic [9:0] phase_out, sin_out, cos_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model state
    logic [23:0] m_acc = '0;
    logic [23:0] m_active = '0;
    logic [23:0] m_shadow = '0;
    bit          m_flip = 1'b0;

    always #5 clk = ~clk;

    subcarrier_dds u0 (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_byte(cfg_byte), .ofs_msb(ofs_msb), .ofs_lo(ofs_lo),
        .seed(seed), .fmt_sel(fmt_sel), .line_start(line_start),
        .sync_ref(sync_ref), .reset_en(reset_en),
        .phase_out(phase_out), .sin_out(sin_out), .cos_out(cos_out)
    );

    function automatic int ref_wave(int p);
        int q = (p >> 8) & 3;
        int i = p & 255;
        int k = (q & 1) ? 256 - i : i;
        int m = (511 * k * (512 - k)) / 65536;
        return (q & 2) ? -m : m;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int s10(logic [9:0] v);
        return int'($signed(v));
    endfunction

    task automatic check_all(string tag);
        int ep = int'(m_acc[23:14]);
        int ec = ref_wave((ep + 256) & 1023);
        if (m_flip) ec = -ec;
        check({tag, " phase"}, int'(phase_out), ep);
        check({tag, " sin R6"}, s10(sin_out), ref_wave(ep));
        check({tag, " cos R7"}, s10(cos_out), ec);
    endtask

    // one clock: model follows the inputs the design samples at this edge
    task automatic step();
        logic [23:0] old_shadow = m_shadow;
        @(posedge clk);
        if (sync_ref && reset_en)
            m_acc = {seed, ofs_msb, ofs_lo, 7'b0};
        else
            m_acc = m_acc + m_active;
        if (line_start) m_active = old_shadow;
        if (cfg_wr) begin
            case (cfg_sel)
                2'd0: m_shadow[7:0]   = cfg_byte;
                2'd1: m_shadow[15:8]  = cfg_byte;
                2'd2: m_shadow[23:16] = cfg_byte;
                default: ;
            endcase
        end
        if (fmt_sel != 2'b01) m_flip = 1'b0;
        else if (line_start) m_flip = ~m_flip;
        @(negedge clk);
        cfg_wr = 1'b0; line_start = 1'b0; sync_ref = 1'b0;
    endtask

    task automatic wr_byte(logic [1:0] s, logic [7:0] d);
        cfg_wr = 1'b1; cfg_sel = s; cfg_byte = d;
        step();
    endtask

    task automatic new_line();
        line_start = 1'b1;
        step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset values
        check("R1 phase", int'(phase_out), 0);
        check("R1 sin", s10(sin_out), 0);
        check("R1 cos", s10(cos_out), 511);

        // R3: shadow writes (incl. ignored select 3) leave the step at zero
        wr_byte(2'd0, 8'h00);
        wr_byte(2'd1, 8'h40);
        wr_byte(2'd2, 8'h00);
        wr_byte(2'd3, 8'hFF);
        check_all("R3 no early effect");
        check("R3 held", int'(phase_out), 0);

        // R4: line start applies the full word one cycle later
        new_line();
        check_all("R4 taken");
        step();
        check_all("R4 stepping");
        check("R4 one unit", int'(phase_out), 1);

        // R2/R6/R7: sweep every phase point, NTSC
        for (int n = 0; n < 1100; n++) begin
            step();
            check_all("R2 sweep");
        end

        // R2 wrap with an odd large step
        wr_byte(2'd0, 8'h37);
        wr_byte(2'd1, 8'hF0);
        wr_byte(2'd2, 8'hE1);
        new_line();
        for (int n = 0; n < 200; n++) begin
            step();
            check_all("R2 wrap");
        end

        // R5: phase load on an enabled line
        seed = 8'hA5; ofs_msb = 1'b1; ofs_lo = 8'h3C;
        sync_ref = 1'b1; reset_en = 1'b1;
        step();
        check_all("R5 load");
        check("R5 loaded acc", int'(phase_out), int'({8'hA5, 1'b1, 1'b0}));
        // R5: sync_ref ignored when not enabled
        reset_en = 1'b0; sync_ref = 1'b1;
        step();
        check_all("R5 ignored");

        // R8: freeze phase with a zero step, then alternate lines in PAL
        wr_byte(2'd0, 8'h00);
        wr_byte(2'd1, 8'h00);
        wr_byte(2'd2, 8'h00);
        new_line();
        fmt_sel = 2'b01;
        for (int n = 0; n < 6; n++) begin
            new_line();
            check_all("R8 pal");
            check("R8 flip parity", s10(cos_out),
                  (n % 2 == 0) ? -ref_wave((int'(m_acc[23:14]) + 256) & 1023)
                               :  ref_wave((int'(m_acc[23:14]) + 256) & 1023));
        end
        // R8: reserved formats behave like NTSC
        for (int f = 2; f < 4; f++) begin
            fmt_sel = 2'(f);
            new_line();
            new_line();
            check_all("R8 reserved");
        end
        fmt_sel = 2'b00;
        new_line();
        check_all("R8 ntsc");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule